// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Generator

This block takes one free-running input clock and produces three single-cycle clock-enable strobes for a CPU domain, a bus domain and a peripheral domain. Logic in each domain runs on the input clock and advances only in cycles where its strobe is high. The block does not gate the clock itself. Each strobe repeats once every N input cycles. N is picked per domain from a fixed, non-uniform table, so ratios such as 3, 5 and 6 give evenly spaced single-cycle pulses.

A single 9-bit frequency-control register sets all three ratios. It is written and read back over a minimal register port: a write strobe, write data and a read-data bus that always shows the current value. A ratio change never cuts a running interval short. Each domain finishes the interval it has started and picks up the new ratio at its next pulse. Every write also produces a one-cycle update pulse. Dependent logic, for example a serial baud-rate generator, uses it to recompute its own timing.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the register and the counters leave reset two clock edges after the reset pin rises.

Top module: `ckdiv_gen`

## Requirements
- R1: While reset is active, and until the second rising clock edge after the reset pin is released, all strobes and the update pulse are low. In the first cycle after that, the register reads 0, the CPU and bus strobes are high in every cycle, and the peripheral strobe is high in every second cycle, starting in that first cycle.
- R2: Register bits 8:6 choose the CPU ratio. Codes 0,1,2,3,4,5,6,7 give ratios 1,2,3,4,5,8,8,8.
- R3: Register bits 5:3 choose the bus ratio and use the same code-to-ratio table as the CPU field.
- R4: Register bits 2:0 choose the peripheral ratio. Codes 0,1,2,3,4,5,6,7 give ratios 2,3,4,6,8,8,8,8.
- R5: Every strobe pulse is exactly one input cycle wide and two consecutive pulses of a domain are exactly N cycles apart. A domain whose ratio is 1 keeps its strobe high in every cycle.
- R6: The interval that begins with a pulse uses the ratio held in the register during that pulse's cycle. A write therefore takes effect at the domain's next pulse and never shortens or stretches the interval already running.
- R7: The update pulse is high for exactly the one cycle that follows each clock edge at which a write is accepted, and is low in all other cycles.
- R8: From the cycle after a write, the read-data bus shows exactly the written value and holds it until the next write.
- R9: The three domains count independently. A change to one field never moves the pulses of another domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock from which all strobes are derived |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| cfg_wr | input | 1 | Write strobe for the frequency-control register |
| cfg_wdata | input | 9 | Value to write: CPU code 8:6, bus code 5:3, peripheral code 2:0 |
| cfg_rdata | output | 9 | Current register contents |
| dom_ce | output | 3 | Strobes: bit 0 CPU, bit 1 bus, bit 2 peripheral |
| rate_upd | output | 1 | One-cycle pulse after each register write |

## Verification
The checker assumes that no write arrives while the internal reset is still held. In that window the register ignores writes, so the readback and update-pulse properties would not apply. The bench keeps to this by issuing its first write several cycles after every reset release. The interval checks assume that a ratio code may change in any cycle, including the cycle of a pulse. The stimulus writes in such cycles and also writes on consecutive edges, so the boundary rule is exercised in both cases. Codes 5 to 7 are written as well, because they share their ratio with a lower code.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  // Width of one divider code field; tables below cover 2**CODE_W codes.
  localparam int CODE_W  = 3;
  localparam int NUM_DOM = 3;
  localparam int CFG_W   = CODE_W * NUM_DOM;
  // Largest ratio is 8, so a countdown of ratio-1 fits in CNT_W bits.
  localparam int CNT_W   = 3;
  localparam int RATIO_W = CNT_W + 1;

  typedef enum logic [1:0] {
    DOM_CPU = 2'd0,
    DOM_BUS = 2'd1,
    DOM_PER = 2'd2
  } dom_e;

  typedef enum logic {
    TBL_CORE   = 1'b0,
    TBL_PERIPH = 1'b1
  } tbl_e;

  // Ratio table shared by the CPU and bus fields.
  function automatic logic [RATIO_W-1:0] core_ratio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd3;
      3'd3:    r = 4'd4;
      3'd4:    r = 4'd5;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  // Ratio table of the peripheral field.
  function automatic logic [RATIO_W-1:0] periph_ratio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd2;
      3'd1:    r = 4'd3;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ckdiv_rst_sync.sv
module ckdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ckdiv_cfg_reg.sv
module ckdiv_cfg_reg
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             upd
);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             upd_q, upd_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
    upd_d = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      upd_q <= upd_d;
    end
  end

  assign cfg = cfg_q;
  assign upd = upd_q;

endmodule

// File: rtl/ckdiv_ratio_lut.sv
module ckdiv_ratio_lut
  import ckdiv_pkg::*;
#(
  parameter tbl_e TBL = TBL_CORE
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio
);

  generate
    if (TBL == TBL_PERIPH) begin : g_periph
      always_comb ratio = periph_ratio(code);
    end else begin : g_core
      always_comb ratio = core_ratio(code);
    end
  endgenerate

endmodule

// File: rtl/ckdiv_strobe.sv
module ckdiv_strobe
  import ckdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ce
);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] reload;
  logic               at_edge;

  // Pulse cycle: count is zero. Reload samples the ratio only here.
  always_comb begin
    at_edge = (cnt_q == '0);
    reload  = ratio - 1'b1;
    cnt_d   = cnt_q;
    if (run) begin
      if (at_edge) cnt_d = reload[CNT_W-1:0];
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ce = run & at_edge;

endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen
  import ckdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic [NUM_DOM-1:0] dom_ce,
  output logic               rate_upd
);

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_q;

  ckdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ckdiv_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg_q),
    .upd   (rate_upd)
  );

  // Domain d takes its code from the field counted down from the top bits:
  // CPU 8:6, bus 5:3, peripheral 2:0.
  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      localparam tbl_e DTBL = (d == int'(DOM_PER)) ? TBL_PERIPH : TBL_CORE;
      logic [CODE_W-1:0]  code;
      logic [RATIO_W-1:0] ratio;

      assign code = cfg_q[(NUM_DOM-1-d)*CODE_W +: CODE_W];

      ckdiv_ratio_lut #(.TBL(DTBL)) u_lut (
        .code  (code),
        .ratio (ratio)
      );

      ckdiv_strobe u_stb (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .run   (rst_sync_n),
        .ratio (ratio),
        .ce    (dom_ce[d])
      );
    end
  endgenerate

  assign cfg_rdata = cfg_q;

endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk
  import ckdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [CFG_W-1:0]   cfg_wdata,
  input logic [CFG_W-1:0]   cfg_rdata,
  input logic [NUM_DOM-1:0] dom_ce,
  input logic               rate_upd
);

  AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |-> (dom_ce == '0 && !rate_upd)); // R1
  AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> rate_upd); // R7
  AST_NO_STRAY_UPD: assert property (@(posedge clk) disable iff (!rst_n) !cfg_wr |=> !rate_upd); // R7
  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr |=> cfg_rdata == $past(cfg_wdata)); // R8
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cfg_wr |=> $stable(cfg_rdata)); // R8

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_gap
      logic [CODE_W-1:0]  fld;
      logic [RATIO_W-1:0] want;
      logic [RATIO_W-1:0] gap_q, exp_q;
      logic               seen_q;

      assign fld  = cfg_rdata[(NUM_DOM-1-d)*CODE_W +: CODE_W];
      assign want = (d == int'(DOM_PER)) ? periph_ratio(fld) : core_ratio(fld);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gap_q  <= '0;
          exp_q  <= '0;
          seen_q <= 1'b0;
        end else if (dom_ce[d]) begin
          gap_q  <= 4'd1;
          exp_q  <= want;
          seen_q <= 1'b1;
        end else if (gap_q != 4'hF) begin
          gap_q  <= gap_q + 1'b1;
        end
      end

      AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && dom_ce[d]) |-> gap_q == exp_q); // R5
      AST_NO_LATE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (seen_q && !dom_ce[d]) |-> gap_q < exp_q); // R6
    end
  endgenerate

endmodule

bind ckdiv_gen ckdiv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .dom_ce    (dom_ce),
  .rate_upd  (rate_upd)
);

// File: tb/sim_ckdiv_gen.sv
module sim_ckdiv_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic [8:0] cfg_rdata;
  logic [2:0] dom_ce;
  logic       rate_upd;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // Reference state: behavioural, integers only.
  int core_tab [8] = '{1, 2, 3, 4, 5, 8, 8, 8};
  int per_tab  [8] = '{2, 3, 4, 6, 8, 8, 8, 8};
  int live_edges = 0;   // edges seen with the reset pin high
  int m_cfg  = 0;
  int m_upd  = 0;
  int wait_c [3] = '{0, 0, 0};   // cycles left until each domain pulses

  always #2 clk = ~clk;

  ckdiv_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dom_ce    (dom_ce),
    .rate_upd  (rate_upd)
  );

  function automatic int dom_ratio(int d, int cfg);
    int code = (cfg >> (3 * (2 - d))) & 7;
    return (d == 2) ? per_tab[code] : core_tab[code];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      live_edges = 0; m_cfg = 0; m_upd = 0;
      for (int d = 0; d < 3; d++) wait_c[d] = 0;
    end else if (live_edges < 2) begin
      live_edges++;
    end else begin
      for (int d = 0; d < 3; d++)
        wait_c[d] = (wait_c[d] == 0) ? dom_ratio(d, m_cfg) - 1 : wait_c[d] - 1;
      m_upd = cfg_wr ? 1 : 0;
      if (cfg_wr) m_cfg = int'(cfg_wdata);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      bool_cmp();
    end
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic bool_cmp();
    bit up = (live_edges >= 2);
    if (!up) begin
      check("R1 strobes quiet in reset", int'(dom_ce), 0);
      check("R1 update quiet in reset", int'(rate_upd), 0);
    end else begin
      check("R2 R5 R6 R9 cpu strobe", int'(dom_ce[0]), (wait_c[0] == 0) ? 1 : 0);
      check("R3 R5 R6 R9 bus strobe", int'(dom_ce[1]), (wait_c[1] == 0) ? 1 : 0);
      check("R4 R5 R6 R9 peripheral strobe", int'(dom_ce[2]), (wait_c[2] == 0) ? 1 : 0);
      check("R7 update pulse", int'(rate_upd), m_upd);
      check("R8 readback", int'(cfg_rdata), m_cfg);
    end
  endtask

  task automatic write_cfg(logic [8:0] v);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    idle(6);
  endtask

  initial begin
    idle(4);
    #1 rst_n = 1'b1;
    // R1: default ratios 1/1/2 straight after release.
    idle(12);
    // R4: peripheral ratio 3 alone; R9 cpu/bus unaffected.
    write_cfg(9'b000_000_001);
    idle(20);
    // R2 R3 R4: odd mixed ratios 3, 5, 6.
    write_cfg({3'd2, 3'd4, 3'd3});
    idle(40);
    // Every code in every field, including the aliased codes 5..7.
    for (int c = 0; c < 8; c++) begin
      write_cfg({c[2:0], c[2:0], c[2:0]});
      idle(25);
    end
    // Different code per field, rotated.
    for (int c = 0; c < 8; c++) begin
      write_cfg({c[2:0], 3'(c + 3), 3'(7 - c)});
      idle(c + 3);
    end
    // R6 R7: writes on consecutive edges, landing inside running intervals.
    @(negedge clk); #1;
    for (int k = 0; k < 12; k++) begin
      cfg_wr = 1'b1;
      cfg_wdata = 9'((k * 73) ^ 9'h0A5);
      @(negedge clk); #1;
    end
    cfg_wr = 1'b0;
    idle(30);
    // Slowest ratio everywhere, then back to fastest mid-interval.
    write_cfg({3'd5, 3'd6, 3'd7});
    idle(3);
    write_cfg(9'd0);
    idle(20);
    // R1: reset during operation returns to defaults.
    write_cfg({3'd3, 3'd1, 3'd3});
    idle(10);
    do_reset();
    idle(10);
    write_cfg({3'd1, 3'd2, 3'd2});
    idle(30);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule